// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block collects 96 level-sensitive interrupt lines, grouped as three banks of 32, and presents them to a processor on two request lines. The normal request line is raised for every unmasked active source. The fast request line is raised only for unmasked active sources whose routing bit is set. Alongside the two lines, the block publishes a vector word equal to four times the index of the lowest-numbered unmasked active source. Software can use this word directly as a byte offset into a handler table.

Software reaches all of its state through a small register bus with a one-cycle read latency. The banked state is held as one word per bank for each of the following: input-following pending state, sticky fast-request capture, routing, enable and mask. Three free control words (base address, protect, NMI) sit next to the read-only vector word. The enable bank is stored but gates nothing. Only the mask suppresses a source.

Top module: `vec_intc`

## Requirements
- R1: Each source's pending bit takes the level of its input line at every clock edge. A change on `src_i` therefore appears in the pending word (group 0x10, word = bank) and on the outputs one cycle later.
- R2: `irq_o` is high exactly when some source is pending and its mask bit (group 0x50, word = bank, bit = source mod 32) is 0.
- R3: `fiq_o` is high exactly when some source is pending, unmasked and has its routing bit (group 0x30) set. `fiq_o` is never high without `irq_o`.
- R4: `vec_o` and the vector word at 0x000 equal 4 × (bank×32 + bit) of the lowest-numbered unmasked pending source, with bank 0 first and the lowest bit within a bank first. The value is 0 when no such source exists.
- R5: Bus writes to the pending words (0x010–0x018) change nothing.
- R6: A fast-request capture bit (group 0x20) is set on every cycle in which its source qualifies for `fiq_o`. A write clears each capture bit whose data bit is 1. When a clear and a capture meet in the same cycle, the bit stays set.
- R7: A write to the base-address word at 0x004 stores the data with bits [1:0] forced to 0. The protect (0x008) and NMI (0x00C) words store the full data.
- R8: After reset, every register reads 0, and `irq_o`, `fiq_o` and `vec_o` are 0.
- R9: Each bank group uses word index = `bus_addr[3:2]`, and index 3 is unmapped. Unmapped, unaligned or out-of-window addresses (0x060 and above) read as 0, and writes to them change nothing.
- R10: `bus_rdata` takes the read value on the clock edge that accepts a read (`bus_vld`=1, `bus_we`=0) and holds it at all other times.
- R11: The enable words (group 0x40) read back what was written and have no effect on `irq_o`, `fiq_o` or `vec_o`.
- R12: Mask and routing writes act on the outputs from the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level interrupt lines, bit n = source n |
| bus_vld | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | 32 | Byte-offset vector of the winning source |

## Verification
Two actions can fall in the same cycle: a write-one-to-clear on the capture word, and a fresh capture from a source that still qualifies for the fast line. The bench provokes this by clearing the capture bit while the routed source is held high. It expects the bit to read back as still set. It then drops the source and repeats the clear, and expects the bit to read back as 0. This shows that the first result came from the capture winning the race and not from a clear that had no effect.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int WORD_W = 32;
  // address group codes taken from bus_addr[AW-1:4]
  localparam int G_CTRL  = 0;
  localparam int G_PEND  = 1;
  localparam int G_FCAP  = 2;
  localparam int G_ROUTE = 3;
  localparam int G_EN    = 4;
  localparam int G_MASK  = 5;

  typedef struct packed {
    logic fclr;
    logic route;
    logic en;
    logic mask;
  } bank_wr_t;
endpackage

// File: rtl/vec_intc_bank.sv
module vec_intc_bank
  import vec_intc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  bank_wr_t     wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] fcap_o,
  output logic [W-1:0] route_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] act_o,
  output logic [W-1:0] fact_o
);
  logic [W-1:0] pend_q, fcap_q, route_q, en_q, mask_q;
  logic [W-1:0] fcap_d;

  assign act_o  = pend_q & ~mask_q;
  assign fact_o = act_o & route_q;

  always_comb begin
    fcap_d = fcap_q;
    if (wr.fclr) fcap_d = fcap_q & ~wdata;
    fcap_d = fcap_d | fact_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fcap_q  <= '0;
      route_q <= '0;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      pend_q <= src;
      fcap_q <= fcap_d;
      if (wr.route) route_q <= wdata;
      if (wr.en)    en_q    <= wdata;
      if (wr.mask)  mask_q  <= wdata;
    end
  end

  assign pend_o  = pend_q;
  assign fcap_o  = fcap_q;
  assign route_o = route_q;
  assign en_o    = en_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/vec_intc_prio.sv
module vec_intc_prio #(
  parameter int N  = 96,
  parameter int VW = 32
) (
  input  logic [N-1:0]  act,
  output logic [VW-1:0] vec
);
  localparam int IW = $clog2(N);
  logic [IW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) idx = IW'(i);
    end
  end

  assign vec = VW'(idx) << 2;
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int AW    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*WORD_W-1:0] src_i,
  input  logic                    bus_vld,
  input  logic                    bus_we,
  input  logic [AW-1:0]           bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    irq_o,
  output logic                    fiq_o,
  output logic [WORD_W-1:0]       vec_o
);
  localparam int NSRC = NBANK * WORD_W;
  localparam int GW   = AW - 4;

  logic [GW-1:0] grp;
  logic [1:0]    widx;
  logic          aligned, wr_en, rd_en;

  assign grp     = bus_addr[AW-1:4];
  assign widx    = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_vld & bus_we & aligned;
  assign rd_en   = bus_vld & ~bus_we;

  logic [WORD_W-1:0] pend_w  [NBANK];
  logic [WORD_W-1:0] fcap_w  [NBANK];
  logic [WORD_W-1:0] route_w [NBANK];
  logic [WORD_W-1:0] en_w    [NBANK];
  logic [WORD_W-1:0] mask_w  [NBANK];
  logic [NSRC-1:0]   act_all, fact_all;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bank_wr_t wr_b;
    logic     hit_b;
    assign hit_b      = wr_en & (widx == 2'(b));
    assign wr_b.fclr  = hit_b & (grp == GW'(G_FCAP));
    assign wr_b.route = hit_b & (grp == GW'(G_ROUTE));
    assign wr_b.en    = hit_b & (grp == GW'(G_EN));
    assign wr_b.mask  = hit_b & (grp == GW'(G_MASK));

    vec_intc_bank #(.W(WORD_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_i[b*WORD_W +: WORD_W]),
      .wr      (wr_b),
      .wdata   (bus_wdata),
      .pend_o  (pend_w[b]),
      .fcap_o  (fcap_w[b]),
      .route_o (route_w[b]),
      .en_o    (en_w[b]),
      .mask_o  (mask_w[b]),
      .act_o   (act_all[b*WORD_W +: WORD_W]),
      .fact_o  (fact_all[b*WORD_W +: WORD_W])
    );
  end

  vec_intc_prio #(.N(NSRC), .VW(WORD_W)) prio_i (
    .act (act_all),
    .vec (vec_o)
  );

  assign irq_o = |act_all;
  assign fiq_o = |fact_all;

  // control words: base, protect, nmi
  logic [WORD_W-1:0] base_q, base_d, prot_q, prot_d, nmi_q, nmi_d;
  logic              base_we, prot_we, nmi_we;
  logic              ctrl_hit;

  assign ctrl_hit = wr_en & (grp == GW'(G_CTRL));
  assign base_we  = ctrl_hit & (widx == 2'd1);
  assign prot_we  = ctrl_hit & (widx == 2'd2);
  assign nmi_we   = ctrl_hit & (widx == 2'd3);

  always_comb begin
    base_d = {bus_wdata[WORD_W-1:2], 2'b00};
    prot_d = bus_wdata;
    nmi_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else begin
      if (base_we) base_q <= base_d;
      if (prot_we) prot_q <= prot_d;
      if (nmi_we)  nmi_q  <= nmi_d;
    end
  end

  // read path
  logic [WORD_W-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    if (aligned) begin
      if (grp == GW'(G_CTRL)) begin
        case (widx)
          2'd0:    rd_d = vec_o;
          2'd1:    rd_d = base_q;
          2'd2:    rd_d = prot_q;
          default: rd_d = nmi_q;
        endcase
      end else begin
        for (int b = 0; b < NBANK; b++) begin
          if (widx == 2'(b)) begin
            if (grp == GW'(G_PEND))  rd_d = pend_w[b];
            if (grp == GW'(G_FCAP))  rd_d = fcap_w[b];
            if (grp == GW'(G_ROUTE)) rd_d = route_w[b];
            if (grp == GW'(G_EN))    rd_d = en_w[b];
            if (grp == GW'(G_MASK))  rd_d = mask_w[b];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NSRC = 96,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            bus_vld,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_rdata,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [31:0]     vec_o
);
  AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(src_i) == '0) |-> !irq_o); // R1
  AST_FIQ_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o); // R3
  AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_o == '0)); // R4
  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o < 32'(NSRC * 4)); // R4
  AST_BASE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_vld && !bus_we && bus_addr == AW'(4)) |=> (bus_rdata[1:0] == 2'b00)); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_vld && !bus_we) |=> $stable(bus_rdata)); // R10
endmodule

bind vec_intc vec_intc_chk #(.NSRC(NBANK * 32), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .bus_vld   (bus_vld),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .vec_o     (vec_o)
);

// File: tb/vec_intc_tb_top.sv
`timescale 1ns/1ps
module vec_intc_tb_top;
  localparam int NS = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          vld = 1'b0, we = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata, vec;
  logic          irq, fiq;
  int            n_chk = 0, n_bad = 0;

  always #4 clk = ~clk; // 125 MHz

  vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_vld(vld), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq), .vec_o(vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); vld = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); vld = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); vld = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; vld = 0;
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk); src = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; src = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    bus_wr(10'h030, 32'hFFFF_FFFF); bus_wr(10'h008, 32'h1234); bus_wr(10'h058, 32'h1);
    do_reset();
    chk("R8 irq", {31'd0, irq}, 0);
    chk("R8 fiq", {31'd0, fiq}, 0);
    chk("R8 vec", vec, 0);
    for (int g = 0; g < 6; g++)
      for (int w = 0; w < 4; w++) begin
        bus_rd(10'(g * 16 + w * 4), d);
        chk($sformatf("R8 reg %0h", g * 16 + w * 4), d, 0);
      end
  endtask

  task automatic t_irq_mask();
    logic [31:0] d;
    set_src(NS'(1) << 40);
    chk("R1 pend bank1", 0, 0);
    bus_rd(10'h014, d); chk("R1 pend bank1", d, 32'h100);
    chk("R2 irq on", {31'd0, irq}, 1);
    bus_wr(10'h054, 32'h100);
    chk("R12 mask next cycle", {31'd0, irq}, 0);
    chk("R2 masked vec", vec, 0);
    bus_wr(10'h054, 32'h0);
    chk("R2 unmasked", {31'd0, irq}, 1);
    set_src('0);
    chk("R1 drop", {31'd0, irq}, 0);
  endtask

  task automatic t_vector();
    logic [31:0] d;
    set_src((NS'(1) << 70) | (NS'(1) << 40));
    chk("R4 lowest 40", vec, 160);
    bus_rd(10'h000, d); chk("R4 vector word", d, 160);
    bus_wr(10'h054, 32'h100);
    chk("R4 next 70", vec, 280);
    set_src((NS'(1) << 70) | (NS'(1) << 40) | (NS'(1) << 3));
    chk("R4 bank0 first", vec, 12);
    bus_wr(10'h054, 32'h0);
    set_src('0);
    chk("R4 idle", vec, 0);
  endtask

  task automatic t_pend_ro();
    logic [31:0] d;
    set_src(NS'(1) << 10);
    bus_wr(10'h010, 32'h0);
    bus_rd(10'h010, d); chk("R5 write 0 ignored", d, 32'h400);
    bus_wr(10'h014, 32'hFFFF);
    bus_rd(10'h014, d); chk("R5 write 1 ignored", d, 0);
    chk("R5 irq unchanged vec", vec, 40);
    set_src('0);
  endtask

  task automatic t_fiq();
    logic [31:0] d;
    set_src(NS'(1) << 5);
    chk("R3 unrouted fiq", {31'd0, fiq}, 0);
    bus_wr(10'h030, 32'h20);
    chk("R12 route next cycle", {31'd0, fiq}, 1);
    bus_rd(10'h020, d); chk("R6 captured", d, 32'h20);
    bus_wr(10'h020, 32'h20);
    bus_rd(10'h020, d); chk("R6 capture wins over clear", d, 32'h20);
    bus_wr(10'h050, 32'h20);
    chk("R3 masked fiq", {31'd0, fiq}, 0);
    bus_wr(10'h050, 32'h0);
    set_src('0);
    @(negedge clk);
    bus_rd(10'h020, d); chk("R6 sticky", d, 32'h20);
    bus_wr(10'h020, 32'h20);
    bus_rd(10'h020, d); chk("R6 w1c clears", d, 0);
    chk("R3 fiq idle", {31'd0, fiq}, 0);
    bus_wr(10'h030, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bus_wr(10'h004, 32'hABCD_EF07);
    bus_rd(10'h004, d); chk("R7 base", d, 32'hABCD_EF04);
    bus_wr(10'h008, 32'h0000_0003);
    bus_rd(10'h008, d); chk("R7 protect", d, 32'h3);
    bus_wr(10'h00C, 32'hFFFF_FFFF);
    bus_rd(10'h00C, d); chk("R7 nmi", d, 32'hFFFF_FFFF);
    bus_wr(10'h000, 32'h55);
    bus_rd(10'h000, d); chk("R4 vector read only", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(10'h03C, 32'hFFFF_FFFF);
    bus_rd(10'h03C, d); chk("R9 index3", d, 0);
    bus_wr(10'h060, 32'h1111);
    bus_rd(10'h060, d); chk("R9 out of window", d, 0);
    bus_wr(10'h3FC, 32'h2222);
    bus_rd(10'h3FC, d); chk("R9 top word", d, 0);
    bus_wr(10'h009, 32'h7777);
    bus_rd(10'h008, d); chk("R9 unaligned write", d, 32'h3);
    bus_rd(10'h009, d); chk("R9 unaligned read", d, 0);
    bus_rd(10'h030, d); chk("R9 no stray route", d, 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bus_wr(10'h048, 32'hCAFE_F00D);
    bus_rd(10'h048, d); chk("R11 readback", d, 32'hCAFE_F00D);
    set_src(NS'(1) << 2);
    chk("R11 disabled still irq", {31'd0, irq}, 1);
    chk("R11 vec", vec, 8);
    bus_wr(10'h040, 32'h0);
    chk("R11 irq after en=0", {31'd0, irq}, 1);
    set_src('0);
  endtask

  task automatic t_rd_latency();
    logic [31:0] d;
    bus_wr(10'h00C, 32'h0000_00A5);
    @(negedge clk); vld = 1; we = 0; addr = 10'h00C;
    @(negedge clk); d = rdata; vld = 0; addr = 10'h008;
    chk("R10 one cycle", d, 32'hA5);
    @(negedge clk);
    chk("R10 hold", rdata, 32'hA5);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
      end
    join_none
    do_reset();
    t_reset_state();
    t_irq_mask();
    t_vector();
    t_pend_ro();
    t_fiq();
    t_ctrl();
    t_unmapped();
    t_enable();
    t_rd_latency();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule